// File: doc/BRIEF.md
# Address-Latching Static Memory Core

A clocked behavioural core for a static memory whose pins are all active low: chip enable, write enable and output enable. Each pin is sampled on a system clock. The core finds edges by comparing each sample with the one taken before it. When chip enable falls, the core stores the address bus in an internal register and opens an access cycle. Later movement on the address bus has no effect until chip enable falls again.

While a cycle is open, the core either reads or writes its internal array, depending on write enable. The bidirectional data bus is split into three signals: a data input, a data output and a drive-enable output.

A read first raises the drive enable. Valid data follows one clock later. A write is committed once, on the earlier of two events: write enable rising, or chip enable rising. Write enable may also stay low across a run of chip-enable pulses, which gives back-to-back writes. Chip enable must have stayed high for a minimum number of samples before a falling edge is accepted as a new cycle.

Top module: `sram_latch_core`

## Requirements
- R1: The address is captured from the sample taken in the same clock period as the accepted chip-enable fall. Address changes made one clock later or after have no effect on that cycle.
- R2: A read cycle has chip enable low, write enable high and output enable low. In it, `dq_oe_o` rises 2 clocks after chip enable is driven low, with `dq_o` still 0. `dq_o` carries the addressed word 1 clock later.
- R3: After chip enable is driven high, `dq_oe_o` is 0 and `dq_o` is 0 one clock later.
- R4: While output enable is high, `dq_oe_o` stays 0 through a whole cycle, whatever chip enable does.
- R5: A write cycle stores its word at the address captured at the chip-enable fall.
- R6: When write enable rises before chip enable, the word stored is the data-in value sampled with that write-enable rise. Data changed afterwards in the same cycle is not stored.
- R7: If write enable is held low across several chip-enable pulses, each pulse stores the data-in value sampled with its chip-enable rise, at that pulse's own address.
- R8: `dq_oe_o` is 1 only when chip enable is low, output enable is low and write enable is high inside an open cycle. Whenever `dq_oe_o` is 0, `dq_o` is 0.
- R9: A chip-enable fall that comes after fewer than `EH_MIN` (default 2) high samples is ignored. No address is captured, no output is driven and no write is stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| e_ni | input | 1 | Chip enable, active low |
| w_ni | input | 1 | Write enable, active low |
| g_ni | input | 1 | Output enable, active low |
| a_i | input | ADDR_W (11) | Address bus |
| d_i | input | DATA_W (8) | Data bus, input direction |
| dq_o | output | DATA_W (8) | Data bus, output direction |
| dq_oe_o | output | 1 | Data bus drive enable |

## Verification
Every location is first filled with write enable held low while chip enable pulses. Every location is then read back with ordinary read cycles. A stuck address bit or a lost write in the held-low pattern shows up as a miscompare.

Single writes are ended in two ways: by write enable rising first, with the data changed afterwards, and by chip enable rising while write enable is still low. Each way then proves by read-back which data sample was stored. Reads are also run with the address moved one clock after the fall, with output enable high, and after a chip-enable high pulse that is too short. These separate a correctly latched address, correct output gating and correct cycle rejection from a core that simply follows the pins.

// File: rtl/sram_lat_pkg.sv
package sram_lat_pkg;
  typedef struct packed {
    logic fall_e;
    logic rise_e;
    logic rise_w;
  } pin_edge_t;
endpackage

// File: rtl/sram_pin_sync.sv
module sram_pin_sync #(
  parameter int ADDR_W = 11,
  parameter int DATA_W = 8,
  parameter int EH_MIN = 2
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       e_ni,
  input  logic                       w_ni,
  input  logic                       g_ni,
  input  logic [ADDR_W-1:0]          a_i,
  input  logic [DATA_W-1:0]          d_i,
  output logic                       s_e_o,
  output logic                       s_w_o,
  output logic                       s_g_o,
  output logic                       p_w_o,
  output logic [ADDR_W-1:0]          s_a_o,
  output logic [DATA_W-1:0]          s_d_o,
  output sram_lat_pkg::pin_edge_t    edge_o,
  output logic                       fall_ok_o
);
  localparam int CW = $clog2(EH_MIN + 1);
  localparam logic [CW-1:0] CMAX = CW'(EH_MIN);

  logic s_e, s_w, s_g, p_e, p_w;
  logic [CW-1:0] eh_cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s_e   <= 1'b1;
      s_w   <= 1'b1;
      s_g   <= 1'b1;
      p_e   <= 1'b1;
      p_w   <= 1'b1;
      s_a_o <= '0;
      s_d_o <= '0;
    end else begin
      s_e   <= e_ni;
      s_w   <= w_ni;
      s_g   <= g_ni;
      p_e   <= s_e;
      p_w   <= s_w;
      s_a_o <= a_i;
      s_d_o <= d_i;
    end
  end

  // count high samples of E, saturating at EH_MIN
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                eh_cnt <= CMAX;
    else if (!s_e)              eh_cnt <= '0;
    else if (eh_cnt != CMAX)    eh_cnt <= eh_cnt + 1'b1;
  end

  assign edge_o.fall_e = p_e & ~s_e;
  assign edge_o.rise_e = ~p_e & s_e;
  assign edge_o.rise_w = ~p_w & s_w;
  assign fall_ok_o     = edge_o.fall_e & (eh_cnt >= CMAX);

  assign s_e_o = s_e;
  assign s_w_o = s_w;
  assign s_g_o = s_g;
  assign p_w_o = p_w;
endmodule

// File: rtl/sram_cycle_ctl.sv
module sram_cycle_ctl #(
  parameter int ADDR_W = 11,
  parameter int DATA_W = 8
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  sram_lat_pkg::pin_edge_t  edge_i,
  input  logic                     fall_ok_i,
  input  logic                     p_w_i,
  input  logic [ADDR_W-1:0]        s_a_i,
  input  logic [DATA_W-1:0]        s_d_i,
  output logic                     active_o,
  output logic [ADDR_W-1:0]        addr_o,
  output logic                     wr_en_o,
  output logic [DATA_W-1:0]        wr_data_o
);
  logic active_q;
  logic [ADDR_W-1:0] addr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      addr_q   <= '0;
    end else if (fall_ok_i) begin
      active_q <= 1'b1;
      addr_q   <= s_a_i;
    end else if (edge_i.rise_e) begin
      active_q <= 1'b0;
    end
  end

  // first of W rise or E rise (with W still low) ends the write
  assign wr_en_o   = active_q & (edge_i.rise_w | (edge_i.rise_e & ~p_w_i));
  assign wr_data_o = s_d_i;
  assign active_o  = active_q;
  assign addr_o    = addr_q;
endmodule

// File: rtl/sram_store.sv
module sram_store #(
  parameter int ADDR_W = 11,
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic [DATA_W-1:0] rd_data_o
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk_i) begin
    if (wr_en_i) mem[addr_i] <= wr_data_i;
    rd_data_o <= mem[addr_i];
  end
endmodule

// File: rtl/sram_latch_core.sv
module sram_latch_core #(
  parameter int ADDR_W = 11,
  parameter int DATA_W = 8,
  parameter int EH_MIN = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              e_ni,
  input  logic              w_ni,
  input  logic              g_ni,
  input  logic [ADDR_W-1:0] a_i,
  input  logic [DATA_W-1:0] d_i,
  output logic [DATA_W-1:0] dq_o,
  output logic              dq_oe_o
);
  logic s_e, s_w, s_g, p_w, fall_ok, active, wr_en, vld_q, oe;
  logic [ADDR_W-1:0] s_a, addr;
  logic [DATA_W-1:0] s_d, wr_data, rd_data;
  sram_lat_pkg::pin_edge_t edges;

  sram_pin_sync #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .EH_MIN(EH_MIN)) u_sync (
    .clk_i, .rst_ni, .e_ni, .w_ni, .g_ni, .a_i, .d_i,
    .s_e_o(s_e), .s_w_o(s_w), .s_g_o(s_g), .p_w_o(p_w),
    .s_a_o(s_a), .s_d_o(s_d), .edge_o(edges), .fall_ok_o(fall_ok)
  );

  sram_cycle_ctl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_ctl (
    .clk_i, .rst_ni, .edge_i(edges), .fall_ok_i(fall_ok), .p_w_i(p_w),
    .s_a_i(s_a), .s_d_i(s_d), .active_o(active), .addr_o(addr),
    .wr_en_o(wr_en), .wr_data_o(wr_data)
  );

  sram_store #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_store (
    .clk_i, .wr_en_i(wr_en), .addr_i(addr), .wr_data_i(wr_data),
    .rd_data_o(rd_data)
  );

  assign oe = active & ~s_e & ~s_g & s_w;

  // data becomes valid one clock after the driver turns on
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) vld_q <= 1'b0;
    else         vld_q <= oe;
  end

  assign dq_oe_o = oe;
  assign dq_o    = (oe & vld_q) ? rd_data : '0;
endmodule

// File: rtl/sram_latch_core_chk.sv
module sram_latch_core_chk #(
  parameter int ADDR_W = 11,
  parameter int DATA_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              e_ni,
  input logic              w_ni,
  input logic              g_ni,
  input logic [DATA_W-1:0] dq_o,
  input logic              dq_oe_o,
  input logic              fall_ok,
  input logic              fall_e,
  input logic              rise_e,
  input logic              active,
  input logic [ADDR_W-1:0] addr,
  input logic              wr_en
);
  a_r1_addr_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fall_ok |=> $stable(addr));

  a_r2_oe_before_data: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(dq_oe_o) |-> dq_o == '0);

  a_r8_oe_pins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dq_oe_o |-> ($past(!e_ni) && $past(!g_ni) && $past(w_ni)));

  a_r8_quiet_bus: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !dq_oe_o |-> dq_o == '0);

  a_r9_short_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fall_e && !fall_ok && !active) |=> !active);

  a_r6_one_commit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en |=> !wr_en);

  a_r3_close: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rise_e && !fall_ok) |=> !active);
endmodule

bind sram_latch_core sram_latch_core_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk_i, .rst_ni, .e_ni, .w_ni, .g_ni, .dq_o, .dq_oe_o,
  .fall_ok(fall_ok), .fall_e(edges.fall_e), .rise_e(edges.rise_e),
  .active(active), .addr(addr), .wr_en(wr_en)
);

// File: tb/sram_latch_core_bench.sv
module sram_latch_core_bench;
  localparam int AW = 11;
  localparam int DW = 8;
  localparam int N  = 1 << AW;

  logic clk = 1'b0, rst_n = 1'b0;
  logic e_n = 1'b1, w_n = 1'b1, g_n = 1'b1;
  logic [AW-1:0] a = '0;
  logic [DW-1:0] d = '0;
  logic [DW-1:0] dq;
  logic dq_oe;
  int checks = 0, fails = 0;

  always #10 clk = ~clk;

  sram_latch_core u_sram_latch_core (
    .clk_i(clk), .rst_ni(rst_n), .e_ni(e_n), .w_ni(w_n), .g_ni(g_n),
    .a_i(a), .d_i(d), .dq_o(dq), .dq_oe_o(dq_oe)
  );

  function automatic logic [DW-1:0] pat(input int adr, input int salt);
    return DW'(adr * 13 + salt) ^ DW'(adr >> 8);
  endfunction

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic chk(input string tag, input logic ok, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic rd_cycle(input int adr, input logic [DW-1:0] exp, input string tag);
    a = AW'(adr); w_n = 1'b1; g_n = 1'b0; e_n = 1'b0;
    tick(2);
    chk({tag, " R2 oe on"}, dq_oe === 1'b1, dq_oe, 1);
    chk({tag, " R2 data not yet"}, dq === '0, dq, 0);
    tick(1);
    chk({tag, " R2/R5 data"}, dq === exp, dq, exp);
    e_n = 1'b1;
    tick(1);
    chk({tag, " R3 oe off"}, dq_oe === 1'b0 && dq === '0, dq_oe, 0);
    g_n = 1'b1;
    tick(2);
  endtask

  task automatic t_reset;
    tick(3);
    chk("reset oe", dq_oe === 1'b0, dq_oe, 0);
    chk("reset dq", dq === '0, dq, 0);
  endtask

  // R7: W held low, E pulses; data sampled at E rise
  task automatic t_fill;
    w_n = 1'b0;
    for (int i = 0; i < N; i++) begin
      a = AW'(i); e_n = 1'b0;
      tick(2);
      d = pat(i, 5); e_n = 1'b1;
      tick(2);
    end
    w_n = 1'b1;
    tick(2);
    for (int i = 0; i < N; i++) rd_cycle(i, pat(i, 5), "R7 fill");
  endtask

  // R6 and R8: W rise ends write, later data ignored, no drive while W low
  task automatic t_w_first;
    a = 11'h155; g_n = 1'b0; w_n = 1'b0; e_n = 1'b0;
    tick(3);
    chk("R8 no drive while W low", dq_oe === 1'b0, dq_oe, 0);
    d = 8'hA7; w_n = 1'b1;
    tick(1);
    d = 8'h3C;
    tick(1);
    e_n = 1'b1; g_n = 1'b1;
    tick(3);
    rd_cycle(11'h155, 8'hA7, "R6 W-first");
  endtask

  // R5: single write ended by E rise
  task automatic t_e_first;
    a = 11'h7FF; w_n = 1'b0; e_n = 1'b0;
    tick(2);
    d = 8'h5E; e_n = 1'b1;
    tick(1);
    w_n = 1'b1; d = 8'h00;
    tick(3);
    rd_cycle(11'h7FF, 8'h5E, "R5 E-first");
  endtask

  // R1: address moved after fall
  task automatic t_addr_hold;
    a = 11'h010; w_n = 1'b1; g_n = 1'b0; e_n = 1'b0;
    tick(1);
    a = 11'h020;
    tick(2);
    chk("R1 read latched addr", dq === pat(16, 5), dq, pat(16, 5));
    e_n = 1'b1; g_n = 1'b1;
    tick(3);
    // write with moved address lands on the latched one
    a = 11'h030; w_n = 1'b0; e_n = 1'b0;
    tick(1);
    a = 11'h040;
    tick(1);
    d = 8'hC3; e_n = 1'b1;
    tick(1);
    w_n = 1'b1;
    tick(3);
    rd_cycle(11'h030, 8'hC3, "R1 write latched");
    rd_cycle(11'h040, pat(64, 5), "R1 other untouched");
  endtask

  // R4: G high blocks the driver
  task automatic t_g_high;
    a = 11'h005; w_n = 1'b1; g_n = 1'b1; e_n = 1'b0;
    tick(2);
    chk("R4 oe off", dq_oe === 1'b0, dq_oe, 0);
    tick(2);
    chk("R4 oe still off", dq_oe === 1'b0 && dq === '0, dq_oe, 0);
    e_n = 1'b1;
    tick(3);
  endtask

  // R9: E high too short, fall rejected
  task automatic t_short_high;
    a = 11'h001; w_n = 1'b1; g_n = 1'b0; e_n = 1'b0;
    tick(3);
    e_n = 1'b1;
    tick(1);
    a = 11'h002; e_n = 1'b0;
    tick(3);
    chk("R9 read rejected", dq_oe === 1'b0, dq_oe, 0);
    e_n = 1'b1;
    tick(3);
    a = 11'h001; w_n = 1'b0; g_n = 1'b1; e_n = 1'b0;
    tick(2);
    e_n = 1'b1;
    tick(1);
    a = 11'h003; e_n = 1'b0;
    tick(2);
    d = 8'hEE; e_n = 1'b1;
    tick(1);
    w_n = 1'b1;
    tick(3);
    rd_cycle(11'h003, pat(3, 5), "R9 write rejected");
  endtask

  initial begin
    fork
      begin
        tick(2);
        rst_n = 1'b1;
        t_reset();
        t_fill();
        t_w_first();
        t_e_first();
        t_addr_hold();
        t_g_high();
        t_short_high();
      end
      begin
        repeat (150000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      end
    join_any
    disable fork;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule